// File: doc/BRIEF.md
# Few-Shot Prototype Weight Generator

This block turns the embeddings seen while a new class is being learned into one row of weights, and optionally one bias, for an ordinary linear classifier layer. Each embedding arrives as a stream of signed elements, one per cycle. The last element of each vector is flagged. The block sums the embeddings element by element over a configurable number of shots. It multiplies each sum by a scale factor and divides by the shot count with a right shift. It then saturates the result to a signed 4-bit weight and writes the row to weight memory, one element per cycle.

When distance scoring is selected, the block also writes a bias equal to minus half the squared norm of the quantized prototype. A plain dot product plus that bias then ranks classes the same way as the squared Euclidean distance does, so the downstream argmax needs no separate distance unit. When dot-product scoring is selected, no bias is written.

The destination row is the class index given with the final beat of a class. In append mode it is instead an internal pointer that moves past each class already learned.

Top module: `proto_weight_gen`

## Requirements
- R1: After reset, `w_we`, `b_we` and `done` are low, and the append pointer is zero.
- R2: A class is formed from `cfg_shots` embedding vectors, each ended by a beat with `emb_last` high. Their elements are summed position by position, with the first beat of a vector at position 0. A `cfg_shots` value of 0 acts as 1.
- R3: Each weight equals the floor of (sum × `cfg_scale`) / 2^`cfg_kshift`, computed as an arithmetic right shift on the signed product.
- R4: A weight above +7 is written as +7, and a weight below −8 is written as −8.
- R5: Weights are written in the DIM cycles that directly follow the final beat of a class. `w_col` runs 0 to DIM−1 in ascending order and `w_row` stays constant.
- R6: With `cfg_l2` high, in the cycle after the last weight, `b_we` is high with `b_data` = −floor(Σq²/2) over the written weights q. With `cfg_l2` low, `b_we` never rises.
- R7: `done` is high for exactly one cycle. That cycle directly follows the last write of the class: the bias in L2 mode, otherwise the last weight.
- R8: With `cfg_cont` low, the row is `cls_in` sampled on the final beat. With `cfg_cont` high, the row is the pointer, which advances by one after each class and returns to zero whenever `cfg_cont` is low.
- R9: Beats offered while a row is being written are ignored. Beats past position DIM−1 within a vector are ignored, except that their `emb_last` still ends the vector.
- R10: The sums are cleared after each class, so a class's weights depend only on its own embeddings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| emb_valid | input | 1 | Embedding element present |
| emb_last | input | 1 | Element ends the current vector |
| emb_data | input | EMB_W | Signed embedding element |
| cls_in | input | CLS_W | Class row used when not appending |
| cfg_shots | input | SHOT_W | Vectors per class (0 acts as 1) |
| cfg_scale | input | SCALE_W | Unsigned multiplier on the sums |
| cfg_kshift | input | SHIFT_W | Right shift standing in for shot division |
| cfg_l2 | input | 1 | Distance scoring (writes bias) |
| cfg_cont | input | 1 | Append mode |
| w_we | output | 1 | Weight write enable |
| w_row | output | CLS_W | Weight row |
| w_col | output | COL_W | Weight element index |
| w_data | output | W_W | Signed saturated weight |
| b_we | output | 1 | Bias write enable |
| b_row | output | CLS_W | Bias row |
| b_data | output | B_W | Signed bias |
| done | output | 1 | Class finished pulse |

## Verification
Stale sums or a miscounted shot counter corrupt the very next row written, so they show in `w_data` within DIM cycles of the following class's final beat. A wrong squared-norm register shows one cycle later in `b_data`. A pointer that fails to advance or to clear shows as a repeated or nonzero `w_row` on the next appended class. Each scenario therefore runs back-to-back classes with different data, row sources and garbage beats, and checks every write.

// File: rtl/proto_weight_gen.sv
module proto_weight_gen #(
  parameter int DIM     = 8,
  parameter int EMB_W   = 8,
  parameter int ACC_W   = 18,
  parameter int W_W     = 4,
  parameter int B_W     = 15,
  parameter int CLS_W   = 4,
  parameter int SHOT_W  = 3,
  parameter int SCALE_W = 4,
  parameter int SHIFT_W = 4,
  localparam int COL_W  = $clog2(DIM)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    emb_valid,
  input  logic                    emb_last,
  input  logic signed [EMB_W-1:0] emb_data,
  input  logic [CLS_W-1:0]        cls_in,
  input  logic [SHOT_W-1:0]       cfg_shots,
  input  logic [SCALE_W-1:0]      cfg_scale,
  input  logic [SHIFT_W-1:0]      cfg_kshift,
  input  logic                    cfg_l2,
  input  logic                    cfg_cont,
  output logic                    w_we,
  output logic [CLS_W-1:0]        w_row,
  output logic [COL_W-1:0]        w_col,
  output logic signed [W_W-1:0]   w_data,
  output logic                    b_we,
  output logic [CLS_W-1:0]        b_row,
  output logic signed [B_W-1:0]   b_data,
  output logic                    done
);
  localparam int PROD_W = ACC_W + SCALE_W + 1;
  localparam logic signed [PROD_W-1:0] QMAX = PROD_W'(2 ** (W_W - 1) - 1);
  localparam logic signed [PROD_W-1:0] QMIN = -QMAX - PROD_W'(1);
  localparam logic [ACC_W-1:0] HALF_LIM = ACC_W'(2 ** (B_W - 1));

  typedef enum logic [1:0] {S_ACC, S_WR, S_BIAS} st_t;
  st_t st;

  logic signed [ACC_W-1:0] acc [DIM];
  logic [COL_W:0]          beat;
  logic [SHOT_W-1:0]       shot;
  logic [COL_W-1:0]        wcol;
  logic [CLS_W-1:0]        row, ptr;
  logic [ACC_W-1:0]        sq;

  wire [SHOT_W-1:0] last_shot = (cfg_shots == '0) ? '0 : cfg_shots - SHOT_W'(1);
  wire take       = (st == S_ACC) && emb_valid;
  wire final_beat = take && emb_last && (shot == last_shot);
  wire last_col   = (wcol == COL_W'(DIM - 1));
  wire class_end  = ((st == S_WR) && last_col && !cfg_l2) || (st == S_BIAS);

  for (genvar g = 0; g < DIM; g++) begin : g_acc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc[g] <= '0;
      else if (class_end) acc[g] <= '0;
      else if (take && beat == (COL_W+1)'(g))
        acc[g] <= acc[g] + ACC_W'(emb_data);
    end
  end

  logic signed [ACC_W-1:0]  acc_sel;
  logic signed [PROD_W-1:0] acc_x, scl_x, prod, shr;
  logic signed [W_W-1:0]    q;
  logic signed [2*W_W-1:0]  q2;

  assign acc_sel = acc[wcol];
  assign acc_x   = PROD_W'(acc_sel);
  assign scl_x   = $signed({{(ACC_W+1){1'b0}}, cfg_scale});
  assign prod    = acc_x * scl_x;
  assign shr     = prod >>> cfg_kshift;
  assign q       = (shr > QMAX) ? W_W'(QMAX) : (shr < QMIN) ? W_W'(QMIN) : shr[W_W-1:0];
  assign q2      = q * q;

  wire [ACC_W-1:0] half = {1'b0, sq[ACC_W-1:1]};
  wire [ACC_W-1:0] neg  = ~half + ACC_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_ACC;
      beat <= '0;
      shot <= '0;
      wcol <= '0;
      row  <= '0;
      sq   <= '0;
      done <= 1'b0;
    end else begin
      done <= class_end;
      case (st)
        S_ACC: if (take) begin
          if (emb_last) begin
            beat <= '0;
            shot <= (shot == last_shot) ? '0 : shot + SHOT_W'(1);
          end else if (beat != (COL_W+1)'(DIM)) begin
            beat <= beat + (COL_W+1)'(1);
          end
          if (final_beat) begin
            st   <= S_WR;
            row  <= cfg_cont ? ptr : cls_in;
            wcol <= '0;
            sq   <= '0;
          end
        end
        S_WR: begin
          sq   <= sq + {{(ACC_W-2*W_W){1'b0}}, q2};
          wcol <= wcol + COL_W'(1);
          if (last_col) st <= cfg_l2 ? S_BIAS : S_ACC;
        end
        default: st <= S_ACC;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (!cfg_cont) ptr <= '0;
    else if (class_end) ptr <= ptr + CLS_W'(1);
  end

  assign w_we   = (st == S_WR);
  assign w_row  = row;
  assign w_col  = wcol;
  assign w_data = q;
  assign b_we   = (st == S_BIAS);
  assign b_row  = row;
  assign b_data = (half >= HALF_LIM) ? {1'b1, {(B_W-1){1'b0}}} : neg[B_W-1:0];
endmodule

// File: rtl/proto_weight_gen_chk.sv
module proto_weight_gen_chk #(
  parameter int COL_W = 3,
  parameter int CLS_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_l2,
  input logic             w_we,
  input logic [COL_W-1:0] w_col,
  input logic [CLS_W-1:0] w_row,
  input logic             b_we,
  input logic             done
);
  assert_bias_only_l2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    b_we |-> cfg_l2);

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_we && b_we));

  assert_first_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(w_we) |-> (w_col == '0));

  assert_col_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (w_we && $past(w_we)) |-> (w_col == $past(w_col) + COL_W'(1)) && (w_row == $past(w_row)));

  assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(w_we) || $past(b_we)) && !w_we && !b_we);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind proto_weight_gen proto_weight_gen_chk #(.COL_W(COL_W), .CLS_W(CLS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_l2(cfg_l2), .w_we(w_we), .w_col(w_col),
  .w_row(w_row), .b_we(b_we), .done(done)
);

// File: tb/sim_proto_weight_gen.sv
`timescale 1ns/1ps
module sim_proto_weight_gen;
  localparam int DIM = 8;
  localparam int COL_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic emb_valid = 1'b0, emb_last = 1'b0;
  logic signed [7:0] emb_data = '0;
  logic [3:0] cls_in = '0;
  logic [2:0] cfg_shots = 3'd1;
  logic [3:0] cfg_scale = 4'd1, cfg_kshift = '0;
  logic cfg_l2 = 1'b0, cfg_cont = 1'b0;
  logic w_we, b_we, done;
  logic [3:0] w_row, b_row;
  logic [COL_W-1:0] w_col;
  logic signed [3:0] w_data;
  logic signed [14:0] b_data;

  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  proto_weight_gen u0 (
    .clk(clk), .rst_n(rst_n), .emb_valid(emb_valid), .emb_last(emb_last), .emb_data(emb_data),
    .cls_in(cls_in), .cfg_shots(cfg_shots), .cfg_scale(cfg_scale), .cfg_kshift(cfg_kshift),
    .cfg_l2(cfg_l2), .cfg_cont(cfg_cont), .w_we(w_we), .w_row(w_row), .w_col(w_col),
    .w_data(w_data), .b_we(b_we), .b_row(b_row), .b_data(b_data), .done(done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int elem(input int seed, input int v, input int i, input int big);
    if (big != 0) return ((i % 2) != 0) ? (-100 + v) : (100 - v);
    return ((seed * 7 + v * 13 + i * 5) % 31) - 15;
  endfunction

  // one class: nvec vectors, then checks of every write, bias and done
  task automatic do_class(input string req, input int nvec, input int seed, input int big,
                          input int extra, input int garbage, input int exp_row);
    int s[DIM];
    int sq = 0;
    for (int i = 0; i < DIM; i++) s[i] = 0;
    for (int v = 0; v < nvec; v++) begin
      int nb = DIM + (extra != 0 ? 2 : 0);
      for (int i = 0; i < nb; i++) begin
        @(negedge clk);
        emb_valid = 1'b1;
        emb_last  = (i == nb - 1);
        if (i < DIM) begin
          emb_data = 8'(elem(seed, v, i, big));
          s[i] += elem(seed, v, i, big);
        end else emb_data = 8'sd77;
      end
    end
    @(negedge clk);
    emb_valid = (garbage != 0);
    emb_data  = 8'sd99;
    emb_last  = 1'b1;
    for (int k = 0; k < DIM; k++) begin
      int p = (s[k] * int'(cfg_scale)) >>> int'(cfg_kshift);
      int q = (p > 7) ? 7 : (p < -8) ? -8 : p;
      sq += q * q;
      chk(req, "w_we", int'(w_we), 1);
      chk(req, "w_col", int'(w_col), k);
      chk(req, "w_row", int'(w_row), exp_row);
      chk(req, "w_data", int'(w_data), q);
      @(negedge clk);
    end
    if (cfg_l2) begin
      chk("R6", "b_we", int'(b_we), 1);
      chk("R6", "b_row", int'(b_row), exp_row);
      chk("R6", "b_data", int'(b_data), -(sq / 2));
      chk("R7", "done early", int'(done), 0);
      @(negedge clk);
    end else begin
      chk("R6", "b_we dot", int'(b_we), 0);
    end
    emb_valid = 1'b0;
    emb_last  = 1'b0;
    chk("R7", "done", int'(done), 1);
    chk("R7", "no write at done", int'(w_we | b_we), 0);
    @(negedge clk);
    chk("R7", "done width", int'(done), 0);
  endtask

  task automatic t_reset();
    chk("R1", "w_we", int'(w_we), 0);
    chk("R1", "b_we", int'(b_we), 0);
    chk("R1", "done", int'(done), 0);
  endtask

  task automatic t_dot();
    cfg_l2 = 1'b0; cfg_cont = 1'b0; cfg_shots = 3'd2; cfg_scale = 4'd1; cfg_kshift = 4'd1;
    cls_in = 4'd5;
    do_class("R3", 2, 1, 0, 0, 0, 5);
  endtask

  task automatic t_l2();
    cfg_l2 = 1'b1; cfg_shots = 3'd4; cfg_scale = 4'd3; cfg_kshift = 4'd2; cls_in = 4'd9;
    do_class("R2", 4, 3, 0, 0, 0, 9);
  endtask

  task automatic t_sat();
    cfg_l2 = 1'b1; cfg_shots = 3'd4; cfg_scale = 4'd15; cfg_kshift = 4'd0; cls_in = 4'd2;
    do_class("R4", 4, 0, 1, 0, 0, 2);
  endtask

  task automatic t_zero_shot();
    cfg_l2 = 1'b0; cfg_shots = 3'd0; cfg_scale = 4'd2; cfg_kshift = 4'd3; cls_in = 4'd7;
    do_class("R2", 1, 5, 0, 0, 0, 7);
  endtask

  task automatic t_ignore();
    cfg_l2 = 1'b1; cfg_shots = 3'd3; cfg_scale = 4'd1; cfg_kshift = 4'd1; cls_in = 4'd11;
    do_class("R9", 3, 8, 0, 1, 1, 11);
    do_class("R10", 3, 12, 0, 0, 0, 11);
  endtask

  task automatic t_cont();
    cfg_l2 = 1'b0; cfg_shots = 3'd1; cfg_scale = 4'd1; cfg_kshift = 4'd0; cls_in = 4'd13;
    cfg_cont = 1'b1;
    do_class("R1", 1, 2, 0, 0, 0, 0);
    do_class("R8", 1, 4, 0, 0, 0, 1);
    do_class("R8", 1, 6, 0, 0, 0, 2);
    cfg_cont = 1'b0;
    cls_in = 4'd3;
    do_class("R8", 1, 9, 0, 0, 0, 3);
    cfg_cont = 1'b1;
    do_class("R8", 1, 10, 0, 0, 0, 0);
    cfg_cont = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dot();
    t_l2();
    t_sat();
    t_zero_shot();
    t_ignore();
    t_cont();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule